// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block gathers one non-maskable request, a group of external interrupt lines and a group of on-chip peripheral requests. It picks one winner and hands it to the processor as a registered source index with a request strobe. Each maskable source has its own enable bit and a one-bit priority level. A single mode input selects the masking scheme. In the first scheme one global mask bit gates every maskable source. In the second scheme two mask bits combine so that the high level can be let through while the low level stays blocked.

The processor answers the strobe with a one-cycle acknowledge pulse. The presented index does not change until that pulse arrives. Arbitration restarts on the cycle after the acknowledge. The non-maskable input is edge-triggered and is held until it is acknowledged. Maskable inputs are level-sensitive, and the peripheral that raised one has to withdraw it. While reset or standby is active, nothing is presented.

Top module: `prio_intc`

## Requirements
- R1: While `rstN` is low, or one cycle after `standby` is seen high, `reqValid` is 0. Standby also discards a latched non-maskable request, so once standby ends that request is not presented.
- R2: A rising edge on `nmiIn` is latched. Two clock edges later it is presented as index 0, whatever the mode and mask bits are set to.
- R3: A maskable source whose enable bit is 0 is never presented.
- R4: With `modeSingle`=1: if `maskI`=0, every enabled maskable request is eligible; if `maskI`=1, none is, and only the non-maskable request can be presented.
- R5: With `modeSingle`=0 and `maskI`=0, every enabled maskable request is eligible.
- R6: With `modeSingle`=0, `maskI`=1 and `maskUi`=0, only level-1 maskable requests (level bit = 1) are eligible. A level-0 request stays pending and is presented once it becomes eligible.
- R7: With `modeSingle`=0, `maskI`=1 and `maskUi`=1, no maskable request is eligible.
- R8: The ranking is: the non-maskable request first, then level-1 sources, then level-0 sources. Within one level the lower index wins. External line k has index 1+k and peripheral line k has index 1+NUM_EXT+k.
- R9: While `reqValid` is 1 and `ack` is 0, `reqValid` and `reqIdx` hold their values. An `ack` sampled high drops `reqValid` at that edge, and the next winner is loaded at the following edge.
- R10: Acknowledging index 0 clears the non-maskable latch. Acknowledging a maskable source clears nothing, so if that source's line is still high it is presented again.
- R11: `ack` has no effect while `reqValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| standby | input | 1 | Hardware standby; suppresses all requests |
| nmiIn | input | 1 | Non-maskable request, edge-triggered |
| extReq | input | NUM_EXT | External request lines, level-sensitive |
| extEn | input | NUM_EXT | Per-line enable for external requests |
| extLvl | input | NUM_EXT | Per-line priority level for external requests |
| perReq | input | NUM_PER | Peripheral request lines, level-sensitive |
| perEn | input | NUM_PER | Per-line enable for peripheral requests |
| perLvl | input | NUM_PER | Per-line priority level for peripheral requests |
| modeSingle | input | 1 | 1: a single global mask; 0: two-bit masking |
| maskI | input | 1 | Primary mask bit |
| maskUi | input | 1 | Secondary mask bit, used only when modeSingle is 0 |
| ack | input | 1 | Acknowledge pulse from the CPU |
| reqValid | output | 1 | Request strobe to the CPU |
| reqIdx | output | $clog2(NUM_EXT+NUM_PER+1) | Index of the presented source |

## Verification
The bench builds the block with two external and two peripheral lines. With that size, the full cross product of request, enable, level, mode and both mask bits is only 32768 cases, and the bench applies every one of them. Each presented index is compared against a ranking computed in the bench, which covers every masking tier, every enable pattern and every same-level tie. Directed sequences then cover the non-maskable latch, the hold-until-acknowledge behaviour, re-presentation of a source that stays asserted, a level-0 request pending under the two-bit mask, an acknowledge while idle, and standby.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;

  // Strobes sent from the control unit to the datapath once per cycle
  typedef struct packed {
    logic loadIdx;  // capture the current winner into the index register
    logic nmiDrop;  // the presented non-maskable request was acknowledged
    logic flush;    // standby: drop everything that is pending
  } strobe_t;

  localparam int unsigned NMI_INDEX = 0;

endpackage

// File: rtl/prio_intc_pick.sv
// Returns the lowest set position of a hit vector.
module prio_intc_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     hits,
  output logic             found,
  output logic [IDX_W-1:0] first
);

  always_comb begin
    found = 1'b0;
    first = '0;
    // Scan from the top down so that the lowest set position is written last
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        found = 1'b1;
        first = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/prio_intc_dp.sv
module prio_intc_dp
  import prio_intc_pkg::*;
#(
  parameter int NUM_EXT = 8,
  parameter int NUM_PER = 8,
  localparam int NUM_MSK = NUM_EXT + NUM_PER,
  localparam int IDX_W   = $clog2(NUM_MSK + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiIn,
  input  logic [NUM_EXT-1:0] extReq,
  input  logic [NUM_EXT-1:0] extEn,
  input  logic [NUM_EXT-1:0] extLvl,
  input  logic [NUM_PER-1:0] perReq,
  input  logic [NUM_PER-1:0] perEn,
  input  logic [NUM_PER-1:0] perLvl,
  input  logic               modeSingle,
  input  logic               maskI,
  input  logic               maskUi,
  input  strobe_t            strb,
  output logic               anyWin,
  output logic               curIsNmi,
  output logic [IDX_W-1:0]   reqIdx
);

  localparam int NUM_TIER = 2;  // tier 1 = high level, tier 0 = low level

  logic [NUM_MSK-1:0] srcReq, srcEn, srcLvl;
  logic [NUM_MSK-1:0] tierHits [NUM_TIER];
  logic [NUM_TIER-1:0] tierFound;
  logic [IDX_W-1:0]   tierPos [NUM_TIER];
  logic               tierOpen [NUM_TIER];
  logic               nmiPrev, nmiPend;
  logic [IDX_W-1:0]   winIdx, idxReg;

  // Merge the external and peripheral lines into one source space
  // (external first, so external line k gets the lower position k)
  generate
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
      assign srcReq[e] = extReq[e];
      assign srcEn[e]  = extEn[e];
      assign srcLvl[e] = extLvl[e];
    end
    for (genvar p = 0; p < NUM_PER; p++) begin : g_per
      assign srcReq[NUM_EXT+p] = perReq[p];
      assign srcEn[NUM_EXT+p]  = perEn[p];
      assign srcLvl[NUM_EXT+p] = perLvl[p];
    end
  endgenerate

  // Which tiers the current mask bits let through
  always_comb begin
    tierOpen[0] = !maskI;
    tierOpen[1] = modeSingle ? !maskI : (!maskI || !maskUi);
  end

  generate
    for (genvar t = 0; t < NUM_TIER; t++) begin : g_tier
      for (genvar s = 0; s < NUM_MSK; s++) begin : g_src
        assign tierHits[t][s] = srcReq[s] && srcEn[s] && tierOpen[t] &&
                                (srcLvl[s] == t[0]);
      end
      prio_intc_pick #(.N(NUM_MSK), .IDX_W(IDX_W)) u_pick (
        .hits  (tierHits[t]),
        .found (tierFound[t]),
        .first (tierPos[t])
      );
    end
  endgenerate

  // Non-maskable latch: set on a rising edge; an edge in the same cycle
  // as the acknowledge survives it; standby clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nmiPrev <= 1'b0;
      nmiPend <= 1'b0;
    end else begin
      nmiPrev <= nmiIn;
      if (strb.flush)
        nmiPend <= 1'b0;
      else if (nmiIn && !nmiPrev)
        nmiPend <= 1'b1;
      else if (strb.nmiDrop)
        nmiPend <= 1'b0;
    end
  end

  // Final ranking: the non-maskable request, then the high tier, then the low tier
  always_comb begin
    winIdx = IDX_W'(NMI_INDEX);
    if (!nmiPend) begin
      if (tierFound[1])
        winIdx = tierPos[1] + IDX_W'(1);
      else if (tierFound[0])
        winIdx = tierPos[0] + IDX_W'(1);
    end
  end

  assign anyWin = nmiPend || (|tierFound);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      idxReg <= '0;
    else if (strb.loadIdx)
      idxReg <= winIdx;
  end

  assign reqIdx   = idxReg;
  assign curIsNmi = (idxReg == IDX_W'(NMI_INDEX));

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadIdx && nmiPend |=> idxReg == IDX_W'(NMI_INDEX)); // R8

  AST_NMI_HELD: assert property (@(posedge clk) disable iff (!rstN)
    nmiPend && !strb.nmiDrop && !strb.flush |=> nmiPend); // R2

endmodule

// File: rtl/prio_intc_ctrl.sv
module prio_intc_ctrl
  import prio_intc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    standby,
  input  logic    ack,
  input  logic    anyWin,
  input  logic    curIsNmi,
  output strobe_t strb,
  output logic    presenting
);

  // Two states: idle (arbitrating every cycle) or presenting (frozen)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      presenting <= 1'b0;
    else if (standby)
      presenting <= 1'b0;
    else if (presenting)
      presenting <= !ack;
    else
      presenting <= anyWin;
  end

  always_comb begin
    strb.flush   = standby;
    strb.loadIdx = !standby && !presenting && anyWin;
    strb.nmiDrop = !standby && presenting && ack && curIsNmi;
  end

  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> !presenting); // R1

  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rstN)
    presenting && ack |=> !presenting); // R9

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_EXT = 8,
  parameter int NUM_PER = 8
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   standby,
  input  logic                                   nmiIn,
  input  logic [NUM_EXT-1:0]                     extReq,
  input  logic [NUM_EXT-1:0]                     extEn,
  input  logic [NUM_EXT-1:0]                     extLvl,
  input  logic [NUM_PER-1:0]                     perReq,
  input  logic [NUM_PER-1:0]                     perEn,
  input  logic [NUM_PER-1:0]                     perLvl,
  input  logic                                   modeSingle,
  input  logic                                   maskI,
  input  logic                                   maskUi,
  input  logic                                   ack,
  output logic                                   reqValid,
  output logic [$clog2(NUM_EXT+NUM_PER+1)-1:0]   reqIdx
);

  strobe_t strb;
  logic    anyWin, curIsNmi;

  prio_intc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .standby    (standby),
    .ack        (ack),
    .anyWin     (anyWin),
    .curIsNmi   (curIsNmi),
    .strb       (strb),
    .presenting (reqValid)
  );

  prio_intc_dp #(.NUM_EXT(NUM_EXT), .NUM_PER(NUM_PER)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .nmiIn      (nmiIn),
    .extReq     (extReq),
    .extEn      (extEn),
    .extLvl     (extLvl),
    .perReq     (perReq),
    .perEn      (perEn),
    .perLvl     (perLvl),
    .modeSingle (modeSingle),
    .maskI      (maskI),
    .maskUi     (maskUi),
    .strb       (strb),
    .anyWin     (anyWin),
    .curIsNmi   (curIsNmi),
    .reqIdx     (reqIdx)
  );

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !ack && !standby |=> reqValid && $stable(reqIdx)); // R9

  AST_ALL_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqValid) && $past(maskI) && ($past(modeSingle) || $past(maskUi))
      |-> reqIdx == '0); // R4 R7

endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;

  localparam int NE = 2;
  localparam int NP = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic standby = 1'b0, nmiIn = 1'b0;
  logic [NE-1:0] extReq = '0, extEn = '0, extLvl = '0;
  logic [NP-1:0] perReq = '0, perEn = '0, perLvl = '0;
  logic modeSingle = 1'b0, maskI = 1'b0, maskUi = 1'b0, ack = 1'b0;
  logic reqValid;
  logic [2:0] reqIdx;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  prio_intc #(.NUM_EXT(NE), .NUM_PER(NP)) uut (
    .clk(clk), .rstN(rstN), .standby(standby), .nmiIn(nmiIn),
    .extReq(extReq), .extEn(extEn), .extLvl(extLvl),
    .perReq(perReq), .perEn(perEn), .perLvl(perLvl),
    .modeSingle(modeSingle), .maskI(maskI), .maskUi(maskUi),
    .ack(ack), .reqValid(reqValid), .reqIdx(reqIdx)
  );

  task automatic expect_out(input string tag, input logic expV, input logic [2:0] expI);
    compared++;
    if (reqValid !== expV || (expV && reqIdx !== expI)) begin
      mismatched++;
      $display("FAIL %s: valid=%0b idx=%0d, expected valid=%0b idx=%0d",
               tag, reqValid, reqIdx, expV, expI);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_src();
    extReq = '0; extEn = '0; extLvl = '0;
    perReq = '0; perEn = '0; perLvl = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    // R1: nothing during reset, nothing right after it
    repeat (3) @(negedge clk);
    expect_out("R1 in reset", 1'b0, 3'd0);
    rstN = 1'b1;
    step();
    expect_out("R1 after reset", 1'b0, 3'd0);

    // Full sweep: R3 R4 R5 R6 R7 R8
    for (int c = 0; c < 32768; c++) begin
      logic [3:0] rq, en, lv;
      logic md, mi, mu, hiOk, loOk, found;
      logic [2:0] expI;
      string tag;
      rq = c[3:0]; en = c[7:4]; lv = c[11:8];
      md = c[12]; mi = c[13]; mu = c[14];
      extReq = rq[1:0]; perReq = rq[3:2];
      extEn  = en[1:0]; perEn  = en[3:2];
      extLvl = lv[1:0]; perLvl = lv[3:2];
      modeSingle = md; maskI = mi; maskUi = mu;
      // Eligibility from the requirement table
      if (md)          begin hiOk = !mi; loOk = !mi; tag = "R4 R3 R8"; end
      else if (!mi)    begin hiOk = 1'b1; loOk = 1'b1; tag = "R5 R3 R8"; end
      else if (!mu)    begin hiOk = 1'b1; loOk = 1'b0; tag = "R6 R3 R8"; end
      else             begin hiOk = 1'b0; loOk = 1'b0; tag = "R7 R3 R8"; end
      found = 1'b0;
      expI = 3'd0;
      for (int pass = 1; pass >= 0; pass--) begin
        for (int i = 0; i < 4; i++) begin
          if (!found && rq[i] && en[i] && (lv[i] == pass[0]) &&
              (pass == 1 ? hiOk : loOk)) begin
            found = 1'b1;
            expI = 3'(i + 1);
          end
        end
      end
      step();
      expect_out(tag, found, expI);
      if (reqValid) begin
        ack = 1'b1;
        clear_src();
        step();
        ack = 1'b0;
      end
    end
    clear_src();
    step();

    // R2: non-maskable request passes with everything masked
    modeSingle = 1'b1; maskI = 1'b1;
    extReq = '1; extEn = '1; extLvl = '1;
    nmiIn = 1'b1;
    @(posedge clk); step();
    expect_out("R2 nmi through mask", 1'b1, 3'd0);

    // R9: held while unacknowledged even as inputs change
    maskI = 1'b0;
    for (int k = 0; k < 3; k++) begin
      perReq = 2'(k); perEn = '1;
      step();
      expect_out("R9 hold", 1'b1, 3'd0);
    end
    maskI = 1'b1; clear_src();
    ack = 1'b1;
    step();
    ack = 1'b0;
    expect_out("R9 drop after ack", 1'b0, 3'd0);
    // R10: latch cleared; nmiIn still high gives no new edge
    step(); step();
    expect_out("R10 nmi latch cleared", 1'b0, 3'd0);
    nmiIn = 1'b0;

    // R10: a maskable source is re-presented if still asserted
    modeSingle = 1'b0; maskI = 1'b0; maskUi = 1'b0;
    extReq[0] = 1'b1; extEn[0] = 1'b1;
    step();
    expect_out("R5 level0 accepted", 1'b1, 3'd1);
    ack = 1'b1;
    step();
    ack = 1'b0;
    expect_out("R9 gap after ack", 1'b0, 3'd0);
    step();
    expect_out("R10 maskable re-presented", 1'b1, 3'd1);
    ack = 1'b1; clear_src();
    step();
    ack = 1'b0;

    // R6: level-0 stays pending while level-1 passes
    maskI = 1'b1; maskUi = 1'b0;
    perReq[1] = 1'b1; perEn[1] = 1'b1;
    step(); step(); step();
    expect_out("R6 level0 blocked", 1'b0, 3'd0);
    perReq[0] = 1'b1; perEn[0] = 1'b1; perLvl[0] = 1'b1;
    step();
    expect_out("R6 level1 accepted", 1'b1, 3'd3);
    ack = 1'b1; perReq[0] = 1'b0;
    step();
    ack = 1'b0;
    step();
    expect_out("R6 level0 still pending", 1'b0, 3'd0);
    maskI = 1'b0;
    step();
    expect_out("R6 pending level0 released", 1'b1, 3'd4);
    ack = 1'b1; clear_src();
    step();
    ack = 1'b0;

    // R11: acknowledge while idle does nothing
    ack = 1'b1;
    step();
    expect_out("R11 idle ack", 1'b0, 3'd0);
    extReq[1] = 1'b1; extEn[1] = 1'b1; extLvl[1] = 1'b1;
    step();
    expect_out("R11 load despite ack high", 1'b1, 3'd2);
    clear_src();
    step();
    ack = 1'b0;
    expect_out("R9 drop with ack held", 1'b0, 3'd0);

    // R1: standby suppresses and discards
    extReq[0] = 1'b1; extEn[0] = 1'b1;
    step();
    expect_out("R1 pre-standby", 1'b1, 3'd1);
    standby = 1'b1;
    step();
    expect_out("R1 standby drops strobe", 1'b0, 3'd0);
    nmiIn = 1'b1;
    step(); step();
    expect_out("R1 standby holds quiet", 1'b0, 3'd0);
    clear_src();
    maskI = 1'b1; modeSingle = 1'b1;
    standby = 1'b0;
    step(); step();
    expect_out("R1 nmi discarded by standby", 1'b0, 3'd0);
    nmiIn = 1'b0;
    step();

    finish_run();
  end

endmodule